// File: doc/BRIEF.md
# DMA Channel Transfer Counter and Address Sequencer

This block holds the programming state of a single DMA channel and paces its transfers. Software writes a transfer count, a peripheral base address, a memory base address and a control word through a simple register write/read port. Once the enable bit is set and the count is nonzero, the block raises a transfer request toward a separate data-moving engine. It presents the current peripheral and memory addresses, with their low bits cleared to suit each side's data width.

Each acknowledge from the engine retires one transfer. The live count drops by one and, if incrementing is enabled for a side, that side's address advances by the transfer size. When the final transfer retires, a one-cycle completion pulse is raised. In circular mode, the count and both addresses return to their programmed values and requests continue. Otherwise, the channel stays quiet until software disables it, reprograms the count and enables it again. While the channel is enabled, the count and both base addresses are locked against register writes.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, all four registers read zero, `xfer_req` is low, both address outputs are zero and `done_pulse` is low.
- R2: The count register keeps only write-data bits 15:0. Read-data bits 31:16 of the count register always read zero.
- R3: While the enable bit is 1, writes to the count, peripheral base and memory base registers are ignored, and read-back shows the earlier value.
- R4: `xfer_req` is high only when the enable bit is 1 and the count is nonzero. A zero count keeps it low even while the channel is enabled.
- R5: Each cycle in which `xfer_ack` is high while `xfer_req` is high lowers the count by exactly one.
- R6: The acknowledge that takes the count from 1 to 0 in non-circular mode raises `done_pulse` for the following cycle only. The count then reads 0 and `xfer_req` stays low.
- R7: In circular mode, the acknowledge of the last transfer raises `done_pulse`, reloads the count with the last value software wrote, returns both addresses to their bases and keeps `xfer_req` high.
- R8: An address output clears no bits for width code 00, bit 0 for code 01, and bits 1:0 for codes 10 and 11. Peripheral and memory addresses use their own width fields.
- R9: With a side's increment bit set, each retired transfer adds 1, 2 or 4 to that side's address for width codes 00, 01 and 10/11. With the bit clear, the address holds. While the channel is disabled, the addresses follow their bases.
- R10: `xfer_ack` while `xfer_req` is low changes neither the count, the addresses nor `done_pulse`.
- R11: Register select codes are 0 for control, 1 for count, 2 for peripheral base and 3 for memory base; other codes read zero. The control register layout is: bit 0 enable, bit 1 circular, bit 2 peripheral increment, bit 3 memory increment, bits 5:4 peripheral width, bits 7:6 memory width. Its bits 31:8 read zero, and it is writable at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select for writes |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_sel | input | 3 | Register select for reads |
| reg_rd_data | output | 32 | Read data for the selected register (combinational) |
| xfer_req | output | 1 | Transfer request to the engine |
| xfer_ack | input | 1 | Engine reports one transfer completed |
| xfer_paddr | output | 32 | Current aligned peripheral address |
| xfer_maddr | output | 32 | Current aligned memory address |
| done_pulse | output | 1 | One-cycle pulse after the last transfer retires |

## Verification
A corrupted live count shows up at the count read-back in the cycle right after the faulty acknowledge. It also shows up as a request that stays high or drops at the wrong transfer, and as a completion pulse on the wrong acknowledge. A wrong shadow value appears only at the next circular wrap, when the reloaded count is read back. A fault in a current address register shows on the address outputs one edge after the acknowledge that advanced it. Errors hidden by masking are caught by sweeping the width codes against misaligned bases.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int REG_W  = 32;
    localparam int SEL_W  = 3;

    localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CNT   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_PBASE = 3'd2;
    localparam logic [SEL_W-1:0] SEL_MBASE = 3'd3;

    typedef enum logic [1:0] {
        WID_BYTE = 2'b00,
        WID_HALF = 2'b01,
        WID_WORD = 2'b10,
        WID_RSVD = 2'b11
    } width_e;

    typedef struct packed {
        width_e mwidth;
        width_e pwidth;
        logic   minc;
        logic   pinc;
        logic   circ;
        logic   en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // low address bits cleared for a given width
    function automatic logic [1:0] low_mask(width_e w);
        case (w)
            WID_BYTE: low_mask = 2'b00;
            WID_HALF: low_mask = 2'b01;
            default:  low_mask = 2'b11;
        endcase
    endfunction

    // bytes moved per transfer
    function automatic logic [2:0] step_bytes(width_e w);
        case (w)
            WID_BYTE: step_bytes = 3'd1;
            WID_HALF: step_bytes = 3'd2;
            default:  step_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_chan_count.sv
module dma_chan_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          en,
    input  logic          circ,
    input  logic          ack,
    output logic [CW-1:0] cnt_o,
    output logic          req_o,
    output logic          step_o,
    output logic          reload_o,
    output logic          done_o
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] shadow_q;
    logic          done_q;
    logic          busy;
    logic          ack_ok;
    logic          last;

    assign busy   = en && (cnt_q != '0);
    assign ack_ok = ack && busy;
    assign last   = ack_ok && (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            shadow_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= last;
            if (wr_en && !en) begin
                cnt_q    <= wr_data;
                shadow_q <= wr_data;
            end else if (ack_ok) begin
                cnt_q <= (last && circ) ? shadow_q : cnt_q - CW'(1);
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign req_o    = busy;
    assign step_o   = ack_ok;
    assign reload_o = last && circ;
    assign done_o   = done_q;

    // R3
    locked_shadow_chk: assert property (@(posedge clk) disable iff (rst)
        (en && wr_en) |=> (shadow_q == $past(shadow_q)));

    // R5
    count_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_ok && cnt_q > CW'(1)) |=> (cnt_q == $past(cnt_q) - CW'(1)));

    // R7
    circ_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (last && circ) |=> (cnt_q == $past(shadow_q)));

    // R6
    oneshot_end_chk: assert property (@(posedge clk) disable iff (rst)
        (last && !circ) |=> (done_o && cnt_q == '0 && !req_o));

endmodule

// File: rtl/dma_chan_addr.sv
module dma_chan_addr
    import dma_chan_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    input  logic          en,
    input  logic          inc_en,
    input  width_e        width,
    input  logic          step,
    input  logic          reload,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] addr_o
);

    logic [AW-1:0] base_q;
    logic [AW-1:0] cur_q;
    logic [AW-1:0] incr;

    assign incr = AW'(step_bytes(width));

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else begin
            if (wr_en && !en)
                base_q <= wr_data;
            if (!en || reload)
                cur_q <= base_q;
            else if (step && inc_en)
                cur_q <= cur_q + incr;
        end
    end

    assign base_o = base_q;
    assign addr_o = {cur_q[AW-1:2], cur_q[1:0] & ~low_mask(width)};

    // R9
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && step && inc_en && !reload && !wr_en) |=> (cur_q == $past(cur_q) + $past(incr)));

    // R3
    locked_base_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> (base_q == $past(base_q)));

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W,
    parameter int RW = REG_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr_en,
    input  logic [SW-1:0] reg_wr_sel,
    input  logic [RW-1:0] reg_wr_data,
    input  logic [SW-1:0] reg_rd_sel,
    output logic [RW-1:0] reg_rd_data,
    output logic          xfer_req,
    input  logic          xfer_ack,
    output logic [AW-1:0] xfer_paddr,
    output logic [AW-1:0] xfer_maddr,
    output logic          done_pulse
);

    localparam int NSIDE = 2;

    ctrl_t         ctrl_q;
    logic [CW-1:0] cnt;
    logic          step;
    logic          reload;
    logic          cnt_wr;

    logic [NSIDE-1:0]   side_wr;
    logic [NSIDE-1:0]   side_inc;
    width_e             side_wid  [NSIDE];
    logic [AW-1:0]      side_base [NSIDE];
    logic [AW-1:0]      side_addr [NSIDE];

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (reg_wr_en && reg_wr_sel == SW'(SEL_CTRL))
            ctrl_q <= ctrl_t'(reg_wr_data[CTRL_W-1:0]);
    end

    assign cnt_wr = reg_wr_en && (reg_wr_sel == SW'(SEL_CNT));

    dma_chan_count #(.CW(CW)) u_count (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cnt_wr),
        .wr_data  (reg_wr_data[CW-1:0]),
        .en       (ctrl_q.en),
        .circ     (ctrl_q.circ),
        .ack      (xfer_ack),
        .cnt_o    (cnt),
        .req_o    (xfer_req),
        .step_o   (step),
        .reload_o (reload),
        .done_o   (done_pulse)
    );

    assign side_wr[0]  = reg_wr_en && (reg_wr_sel == SW'(SEL_PBASE));
    assign side_wr[1]  = reg_wr_en && (reg_wr_sel == SW'(SEL_MBASE));
    assign side_inc[0] = ctrl_q.pinc;
    assign side_inc[1] = ctrl_q.minc;
    assign side_wid[0] = ctrl_q.pwidth;
    assign side_wid[1] = ctrl_q.mwidth;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        dma_chan_addr #(.AW(AW)) u_addr (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (side_wr[s]),
            .wr_data (reg_wr_data[AW-1:0]),
            .en      (ctrl_q.en),
            .inc_en  (side_inc[s]),
            .width   (side_wid[s]),
            .step    (step),
            .reload  (reload),
            .base_o  (side_base[s]),
            .addr_o  (side_addr[s])
        );
    end

    assign xfer_paddr = side_addr[0];
    assign xfer_maddr = side_addr[1];

    always_comb begin
        reg_rd_data = '0;
        case (reg_rd_sel)
            SW'(SEL_CTRL):  reg_rd_data = RW'(ctrl_q);
            SW'(SEL_CNT):   reg_rd_data = RW'(cnt);
            SW'(SEL_PBASE): reg_rd_data = RW'(side_base[0]);
            SW'(SEL_MBASE): reg_rd_data = RW'(side_base[1]);
            default:        reg_rd_data = '0;
        endcase
    end

    // R4
    req_gate_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> (ctrl_q.en && cnt != '0));

    // R8
    palign_half_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.pwidth == WID_HALF) |-> (xfer_paddr[0] == 1'b0));

    // R8
    palign_word_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.pwidth == WID_WORD) |-> (xfer_paddr[1:0] == 2'b00));

    // R10
    idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_ack && !xfer_req && !reg_wr_en) |=> ($stable(cnt) && !done_pulse));

endmodule

// File: tb/tb_dma_chan_ctrl.sv
module tb_dma_chan_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [2:0]  reg_wr_sel;
    logic [31:0] reg_wr_data;
    logic [2:0]  reg_rd_sel;
    logic [31:0] reg_rd_data;
    logic        xfer_req;
    logic        xfer_ack;
    logic [31:0] xfer_paddr;
    logic [31:0] xfer_maddr;
    logic        done_pulse;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_ctrl dut (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_sel  (reg_wr_sel),
        .reg_wr_data (reg_wr_data),
        .reg_rd_sel  (reg_rd_sel),
        .reg_rd_data (reg_rd_data),
        .xfer_req    (xfer_req),
        .xfer_ack    (xfer_ack),
        .xfer_paddr  (xfer_paddr),
        .xfer_maddr  (xfer_maddr),
        .done_pulse  (done_pulse)
    );

    // {width code, base, expected aligned address}
    localparam logic [65:0] ALIGN_VEC [8] = '{
        {2'd0, 32'h0000_1003, 32'h0000_1003},
        {2'd1, 32'h0000_1003, 32'h0000_1002},
        {2'd2, 32'h0000_1003, 32'h0000_1000},
        {2'd3, 32'h0000_1007, 32'h0000_1004},
        {2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFE},
        {2'd2, 32'h8000_0002, 32'h8000_0000},
        {2'd0, 32'h0000_0000, 32'h0000_0000},
        {2'd1, 32'h0000_0010, 32'h0000_0010}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_sel  = sel;
        reg_wr_data = data;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] data);
        reg_rd_sel = sel;
        #1;
        data = reg_rd_data;
    endtask

    task automatic ack_once();
        @(negedge clk);
        xfer_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        xfer_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; reg_wr_en = 1'b0; reg_wr_sel = '0; reg_wr_data = '0;
        reg_rd_sel = '0; xfer_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            rd(3'(s), v);
            check("R1 reg", v, 32'h0);
        end
        check("R1 req", {31'd0, xfer_req}, 32'd0);
        check("R1 paddr", xfer_paddr, 32'h0);
        check("R1 maddr", xfer_maddr, 32'h0);
        check("R1 done", {31'd0, done_pulse}, 32'd0);

        // R8 alignment table, channel disabled
        for (int i = 0; i < 8; i++) begin
            wr(3'd2, ALIGN_VEC[i][63:32]);
            wr(3'd3, ALIGN_VEC[i][63:32]);
            wr(3'd0, {24'd0, ALIGN_VEC[i][65:64], ALIGN_VEC[i][65:64], 4'd0});
            @(negedge clk);
            check("R8 paddr", xfer_paddr, ALIGN_VEC[i][31:0]);
            check("R8 maddr", xfer_maddr, ALIGN_VEC[i][31:0]);
        end

        // R11 control layout and select decode
        wr(3'd0, 32'hFFFF_FFB6);
        rd(3'd0, v); check("R11 ctrl readback", v, 32'h0000_00B6);
        rd(3'd5, v); check("R11 unused select", v, 32'h0);
        wr(3'd0, 32'h0);

        // R2 count width
        wr(3'd1, 32'hABCD_1234);
        rd(3'd1, v); check("R2 count upper zero", v, 32'h0000_1234);

        // R4 zero count blocks even when enabled
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h1);
        check("R4 zero count req", {31'd0, xfer_req}, 32'd0);
        ack_once();
        rd(3'd1, v); check("R10 ack on zero count", v, 32'h0);
        check("R10 no done", {31'd0, done_pulse}, 32'd0);
        wr(3'd0, 32'h0);

        // main run: pinc, minc, pw=16-bit, mw=32-bit
        wr(3'd2, 32'h0000_1000);
        wr(3'd3, 32'h0000_2000);
        wr(3'd1, 32'd3);
        wr(3'd0, 32'h9D);
        check("R4 req enabled", {31'd0, xfer_req}, 32'd1);
        check("R9 paddr start", xfer_paddr, 32'h1000);

        // R3 locked while enabled
        wr(3'd1, 32'd9);
        rd(3'd1, v); check("R3 count locked", v, 32'd3);
        wr(3'd2, 32'h5555);
        rd(3'd2, v); check("R3 pbase locked", v, 32'h1000);
        wr(3'd3, 32'h7777);
        rd(3'd3, v); check("R3 mbase locked", v, 32'h2000);

        ack_once();
        rd(3'd1, v); check("R5 count 3->2", v, 32'd2);
        check("R9 paddr +2", xfer_paddr, 32'h1002);
        check("R9 maddr +4", xfer_maddr, 32'h2004);
        ack_once();
        rd(3'd1, v); check("R5 count 2->1", v, 32'd1);
        check("R6 no early done", {31'd0, done_pulse}, 32'd0);
        ack_once();
        check("R6 done pulse", {31'd0, done_pulse}, 32'd1);
        rd(3'd1, v); check("R6 count zero", v, 32'd0);
        check("R6 req low", {31'd0, xfer_req}, 32'd0);
        @(negedge clk);
        check("R6 pulse one cycle", {31'd0, done_pulse}, 32'd0);
        check("R6 still idle", {31'd0, xfer_req}, 32'd0);

        // re-arm: disable, reprogram, enable
        wr(3'd0, 32'h9C);
        wr(3'd1, 32'd2);
        wr(3'd0, 32'h9D);
        check("R9 paddr back to base", xfer_paddr, 32'h1000);
        check("R4 req rearmed", {31'd0, xfer_req}, 32'd1);

        // R10 ack while disabled
        wr(3'd0, 32'h9C);
        ack_once();
        rd(3'd1, v); check("R10 count unchanged", v, 32'd2);
        check("R10 paddr unchanged", xfer_paddr, 32'h1000);

        // R7 circular, pinc only, pw=32-bit, minc off
        wr(3'd0, 32'h27);
        ack_once();
        rd(3'd1, v); check("R5 circ count 2->1", v, 32'd1);
        check("R9 paddr +4", xfer_paddr, 32'h1004);
        check("R9 maddr holds", xfer_maddr, 32'h2000);
        ack_once();
        check("R7 done pulse", {31'd0, done_pulse}, 32'd1);
        rd(3'd1, v); check("R7 count reloaded", v, 32'd2);
        check("R7 paddr reloaded", xfer_paddr, 32'h1000);
        check("R7 req continues", {31'd0, xfer_req}, 32'd1);
        ack_once();
        rd(3'd1, v); check("R7 second lap", v, 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule